// File: doc/BRIEF.md
# Register-Mapped Serial Port with Occupancy Interrupts

This block is an asynchronous serial transmitter and receiver that sits on a simple 32-bit register bus (select, write enable, byte address, write data, read data, ready). Software pushes bytes into an 8-entry transmit queue and pulls bytes out of an 8-entry receive queue through two data registers. The top bit of each data register reports the queue condition that matters to the caller: "cannot accept" on the transmit side, "nothing to give" on the receive side. A read of the receive register that returns a byte also removes that byte from the queue.

Frames are always 8 data bits, least significant bit first, with no parity and a programmable choice of one or two stop bits. A divisor register sets the bit time in clock cycles. Two interrupt conditions compare queue occupancy with programmable levels. The transmit condition asks for more data when the queue runs low. The receive condition asks for service when the queue holds more than a threshold. Each condition has an enable, and the enabled conditions merge onto a single interrupt line.

Top module: `uart_mmio`

## Requirements
- R1: After reset, a read at 0x00 returns 0, a read at 0x04 returns 0x80000000, a read at 0x14 returns 0, `irq` is low and `txd` is high.
- R2: A write at 0x00 appends wdata[7:0] to the transmit queue. A read at 0x00 returns bit 31 set exactly when the queue holds 8 bytes. A write while the queue is full is discarded.
- R3: A read at 0x04 returns 0x80000000 when the receive queue is empty. Otherwise it returns the oldest byte in bits 7:0 with bit 31 clear and removes that byte. Bytes come out in arrival order.
- R4: Register 0x08 holds transmit enable (bit 0), two-stop-bit select (bit 1) and the transmit level (bits 18:16). A frame is one low start bit, then 8 data bits LSB first, then one stop bit (two when bit 1 is set) driven high. When bytes are queued, each frame starts 10×(D+1)+1 cycles after the previous one with one stop bit, or 11×(D+1)+1 cycles with two.
- R5: While transmit enable is 0, queued bytes stay in the queue and `txd` stays high.
- R6: Register 0x0C holds receive enable (bit 0) and the receive level (bits 18:16). A frame that arrives while the receiver is disabled is not stored.
- R7: Register 0x14 is read-only and not sticky. Bit 0 is set while transmit occupancy is below the transmit level. Bit 1 is set while receive occupancy is above the receive level. Writes to 0x14 change nothing.
- R8: Register 0x10 holds the enables, with the same bit positions as 0x14. `irq` is high exactly when some bit is set in both 0x10 and 0x14.
- R9: Register 0x18 holds D, the divisor minus one, in bits 15:0, and resets to 15. One bit time is D+1 clock cycles.
- R10: The receiver samples each bit at mid-bit and discards a frame whose stop bit is sampled low.
- R11: A frame that completes while the receive queue holds 8 bytes is dropped, and the 8 stored bytes are kept.
- R12: `ready` is high in every cycle in which `sel` is high, so each access completes in one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sel | input | 1 | Bus access strobe |
| wrEn | input | 1 | 1 = write, 0 = read |
| addr | input | 5 | Byte address within the 28-byte window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the addressed register |
| ready | output | 1 | Access completes this cycle |
| irq | output | 1 | Combined watermark interrupt |
| txd | output | 1 | Serial output, idle high |
| rxd | input | 1 | Serial input, idle high |

## Verification
Receive overflow is the hardest case to reach from the ports. The receive queue must already hold eight bytes when another well-formed frame finishes. The stimulus queues ten bytes through the transmit register and loops `txd` back to `rxd`. It then leaves the receive queue unread until every frame has landed, and drains it afterwards, expecting exactly the first eight bytes. The bad-stop case uses the same loop with the bench itself driving the serial line, so that a frame can end with a low stop bit.

// File: rtl/uart_mmio_pkg.sv
package uart_mmio_pkg;
  parameter int FIFO_DEPTH = 8;                    // entries per queue, power of two
  parameter int CNT_W      = $clog2(FIFO_DEPTH + 1);
  parameter int LVL_W      = $clog2(FIFO_DEPTH);
  parameter int LVL_LSB    = 16;                   // level field position in control regs
  parameter int DIV_W      = 16;
  parameter int BYTE_W     = 8;
  parameter logic [DIV_W-1:0] DIV_RESET = 16'd15;

  typedef enum logic [2:0] {
    REG_TXDATA = 3'd0,
    REG_RXDATA = 3'd1,
    REG_TXCTL  = 3'd2,
    REG_RXCTL  = 3'd3,
    REG_IEN    = 3'd4,
    REG_IPEND  = 3'd5,
    REG_DIV    = 3'd6
  } regSel_t;

  // control -> datapath strobes
  typedef struct packed {
    logic              txPush;
    logic              rxPop;
    logic [BYTE_W-1:0] txByte;
  } strobe_t;

  // control -> datapath static configuration
  typedef struct packed {
    logic             txEn;
    logic             twoStop;
    logic             rxEn;
    logic [DIV_W-1:0] divisor;
  } cfg_t;

  // datapath -> control status
  typedef struct packed {
    logic [CNT_W-1:0]  txCount;
    logic [CNT_W-1:0]  rxCount;
    logic              txFull;
    logic              rxEmpty;
    logic [BYTE_W-1:0] rxHead;
  } status_t;
endpackage

// File: rtl/uart_mmio_fifo.sv
module uart_mmio_fifo #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic pushOk, popOk;

  assign full   = (count == CNT_W'(DEPTH));
  assign empty  = (count == '0);
  assign pushOk = push && !full;
  assign popOk  = pop && !empty;
  assign head   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (pushOk) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (pushOk) wrPtr <= wrPtr + 1'b1;
      if (popOk)  rdPtr <= rdPtr + 1'b1;
      if (pushOk && !popOk)      count <= count + 1'b1;
      else if (popOk && !pushOk) count <= count - 1'b1;
    end
  end

  // R2 / R11: occupancy never exceeds the depth
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));

  // R2 / R11: a push into a full queue without a pop leaves it full and unchanged
  a_r11_push_full_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (push && full && !pop) |=> (count == CNT_W'(DEPTH)));

  // R3: a pop from an empty queue without a push leaves it empty
  a_r3_pop_empty_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (pop && empty && !push) |=> (count == '0));
endmodule

// File: rtl/uart_mmio_dp.sv
module uart_mmio_dp
  import uart_mmio_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t stb,
  input  cfg_t    cfg,
  input  logic    rxd,
  output status_t st,
  output logic    txd
);
  localparam int FRAME_MAX = 2 + BYTE_W + 1;   // start + data + two stops

  // ---------------- queues ----------------
  logic [BYTE_W-1:0] txHead, rxByte;
  logic [CNT_W-1:0]  txCount, rxCount;
  logic txFull, txEmpty, rxFullUnused, rxEmpty, txPop, rxPush;

  uart_mmio_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(BYTE_W)) txQ (
    .clk, .rstN, .push(stb.txPush), .din(stb.txByte), .pop(txPop),
    .head(txHead), .count(txCount), .full(txFull), .empty(txEmpty));

  uart_mmio_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(BYTE_W)) rxQ (
    .clk, .rstN, .push(rxPush), .din(rxByte), .pop(stb.rxPop),
    .head(st.rxHead), .count(rxCount), .full(rxFullUnused), .empty(rxEmpty));

  assign st.txCount = txCount;
  assign st.rxCount = rxCount;
  assign st.txFull  = txFull;
  assign st.rxEmpty = rxEmpty;

  // ---------------- transmitter ----------------
  logic                 txBusy;
  logic [FRAME_MAX-1:0] txShift;
  logic [3:0]           txBitsLeft;
  logic [DIV_W-1:0]     txBaud;

  assign txPop = !txBusy && cfg.txEn && !txEmpty;
  assign txd   = txShift[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBusy     <= 1'b0;
      txShift    <= '1;
      txBitsLeft <= '0;
      txBaud     <= '0;
    end else if (txPop) begin
      txBusy     <= 1'b1;
      txShift    <= {2'b11, txHead, 1'b0};
      txBitsLeft <= cfg.twoStop ? 4'(FRAME_MAX) : 4'(FRAME_MAX - 1);
      txBaud     <= cfg.divisor;
    end else if (txBusy) begin
      if (txBaud == '0) begin
        txShift    <= {1'b1, txShift[FRAME_MAX-1:1]};
        txBaud     <= cfg.divisor;
        txBitsLeft <= txBitsLeft - 1'b1;
        if (txBitsLeft == 4'd1) txBusy <= 1'b0;
      end else begin
        txBaud <= txBaud - 1'b1;
      end
    end
  end

  // R5: the line rests high whenever no frame is in flight
  a_r5_idle_line_high: assert property (@(posedge clk) disable iff (!rstN)
    !txBusy |-> txd);

  // ---------------- receiver ----------------
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rxState_t;
  rxState_t         rxState;
  logic             rxMeta, rxSync, rxPrev;
  logic [DIV_W-1:0] rxBaud;
  logic [2:0]       rxBitIdx;

  assign rxPush = (rxState == RX_STOP) && (rxBaud == '0) && rxSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxMeta   <= 1'b1;
      rxSync   <= 1'b1;
      rxPrev   <= 1'b1;
      rxState  <= RX_IDLE;
      rxBaud   <= '0;
      rxBitIdx <= '0;
      rxByte   <= '0;
    end else begin
      rxMeta <= rxd;
      rxSync <= rxMeta;
      rxPrev <= rxSync;
      unique case (rxState)
        RX_IDLE: if (cfg.rxEn && rxPrev && !rxSync) begin
          rxState <= RX_START;
          rxBaud  <= cfg.divisor >> 1;
        end
        RX_START: if (rxBaud == '0) begin
          rxState  <= rxSync ? RX_IDLE : RX_DATA;
          rxBaud   <= cfg.divisor;
          rxBitIdx <= '0;
        end else rxBaud <= rxBaud - 1'b1;
        RX_DATA: if (rxBaud == '0) begin
          rxByte   <= {rxSync, rxByte[BYTE_W-1:1]};
          rxBaud   <= cfg.divisor;
          rxBitIdx <= rxBitIdx + 1'b1;
          if (rxBitIdx == 3'(BYTE_W - 1)) rxState <= RX_STOP;
        end else rxBaud <= rxBaud - 1'b1;
        RX_STOP: if (rxBaud == '0) rxState <= RX_IDLE;
                 else rxBaud <= rxBaud - 1'b1;
        default: rxState <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_mmio_ctrl.sv
module uart_mmio_ctrl
  import uart_mmio_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sel,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  status_t           st,
  output logic [31:0]       rdata,
  output logic              ready,
  output logic              irq,
  output strobe_t           stb,
  output cfg_t              cfg
);
  logic             txEn, twoStop, rxEn;
  logic [LVL_W-1:0] txLvl, rxLvl;
  logic [1:0]       intEn, pend;
  logic [DIV_W-1:0] divisor;
  logic             wr, rd;
  regSel_t          regSel;
  logic             unusedBits;

  assign unusedBits = ^{wdata[31:LVL_LSB+LVL_W], addr[1:0]};
  assign regSel = regSel_t'(addr[4:2]);
  assign wr     = sel && wrEn;
  assign rd     = sel && !wrEn;
  assign ready  = sel;

  assign stb.txPush = wr && (regSel == REG_TXDATA);
  assign stb.txByte = wdata[BYTE_W-1:0];
  assign stb.rxPop  = rd && (regSel == REG_RXDATA);

  assign cfg.txEn    = txEn;
  assign cfg.twoStop = twoStop;
  assign cfg.rxEn    = rxEn;
  assign cfg.divisor = divisor;

  // level-style watermark conditions, never latched
  assign pend[0] = st.txCount < CNT_W'(txLvl);
  assign pend[1] = st.rxCount > CNT_W'(rxLvl);
  assign irq     = |(intEn & pend);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txEn    <= 1'b0;
      twoStop <= 1'b0;
      txLvl   <= '0;
      rxEn    <= 1'b0;
      rxLvl   <= '0;
      intEn   <= '0;
      divisor <= DIV_RESET;
    end else if (wr) begin
      unique case (regSel)
        REG_TXCTL: begin
          txEn    <= wdata[0];
          twoStop <= wdata[1];
          txLvl   <= wdata[LVL_LSB +: LVL_W];
        end
        REG_RXCTL: begin
          rxEn  <= wdata[0];
          rxLvl <= wdata[LVL_LSB +: LVL_W];
        end
        REG_IEN: intEn   <= wdata[1:0];
        REG_DIV: divisor <= wdata[DIV_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    unique case (regSel)
      REG_TXDATA: rdata[31] = st.txFull;
      REG_RXDATA: if (st.rxEmpty) rdata[31] = 1'b1;
                  else            rdata[BYTE_W-1:0] = st.rxHead;
      REG_TXCTL: begin
        rdata[0] = txEn;
        rdata[1] = twoStop;
        rdata[LVL_LSB +: LVL_W] = txLvl;
      end
      REG_RXCTL: begin
        rdata[0] = rxEn;
        rdata[LVL_LSB +: LVL_W] = rxLvl;
      end
      REG_IEN:   rdata[1:0] = intEn;
      REG_IPEND: rdata[1:0] = pend;
      REG_DIV:   rdata[DIV_W-1:0] = divisor;
      default:   rdata = '0;
    endcase
  end

  // R12: a data pop is only requested during a bus access
  a_r12_pop_needs_access: assert property (@(posedge clk) disable iff (!rstN)
    stb.rxPop |-> ready);
endmodule

// File: rtl/uart_mmio.sv
module uart_mmio
  import uart_mmio_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sel,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              ready,
  output logic              irq,
  output logic              txd,
  input  logic              rxd
);
  strobe_t stb;
  cfg_t    cfg;
  status_t st;

  uart_mmio_ctrl #(.ADDR_W(ADDR_W)) ctrl (
    .clk, .rstN, .sel, .wrEn, .addr, .wdata, .st,
    .rdata, .ready, .irq, .stb, .cfg);

  uart_mmio_dp dp (
    .clk, .rstN, .stb, .cfg, .rxd, .st, .txd);
endmodule

// File: tb/uart_mmio_test.sv
module uart_mmio_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sel = 1'b0, wrEn = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ready, irq, txd, rxd;
  logic        loopOn = 1'b0, benchRx = 1'b1;
  int          checks = 0, fails = 0, cyc = 0;
  logic [31:0] d;

  assign rxd = loopOn ? txd : benchRx;

  uart_mmio uut (.clk, .rstN, .sel, .wrEn, .addr, .wdata, .rdata,
                 .ready, .irq, .txd, .rxd);

  always #10 clk = ~clk;           // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] v);
    @(negedge clk); sel = 1; wrEn = 1; addr = a; wdata = v;
    @(negedge clk); sel = 0; wrEn = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk); sel = 1; wrEn = 0; addr = a;
    #2 v = rdata;
    @(negedge clk); sel = 0;
  endtask

  task automatic rxGet(output logic [31:0] v);
    for (int i = 0; i < 3000; i++) begin
      rd(5'h04, v);
      if (!v[31]) return;
    end
  endtask

  task automatic pushWait(input logic [7:0] b);
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin
      rd(5'h00, s);
      if (!s[31]) break;
    end
    wr(5'h00, {24'h0, b});
  endtask

  task automatic waitFall(output int at);
    @(negedge clk);
    while (txd !== 1'b0) @(negedge clk);
    at = cyc;
  endtask

  task automatic testReset;
    chk("R1 txd idle", {31'h0, txd}, 32'h1);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    rd(5'h00, d); chk("R1 tx status", d, 32'h0);
    rd(5'h04, d); chk("R1 rx empty", d, 32'h8000_0000);
    rd(5'h14, d); chk("R1 pending", d, 32'h0);
    @(negedge clk); sel = 1; wrEn = 0; addr = 5'h18;
    #2 chk("R12 ready", {31'h0, ready}, 32'h1);
    chk("R9 divisor reset", rdata, 32'd15);
    @(negedge clk); sel = 0;
  endtask

  task automatic testTxFull;
    for (int i = 0; i < 8; i++) wr(5'h00, 32'h10 + i);
    rd(5'h00, d); chk("R2 full flag", d, 32'h8000_0000);
    wr(5'h00, 32'hEE);
    repeat (50) @(negedge clk);
    chk("R5 disabled line high", {31'h0, txd}, 32'h1);
    loopOn = 1;
    wr(5'h0C, 32'h1);
    wr(5'h08, 32'h1);
    for (int i = 0; i < 8; i++) begin
      rxGet(d); chk("R3 order", d, 32'h10 + i);
    end
    repeat (400) @(negedge clk);
    rd(5'h04, d); chk("R2 full write dropped", d, 32'h8000_0000);
    rd(5'h00, d); chk("R2 not full", d, 32'h0);
  endtask

  task automatic testTiming;
    int t1, t2;
    logic [9:0] expBits;
    wr(5'h0C, 32'h0);
    wr(5'h18, 32'd19);
    wr(5'h00, 32'h35);
    expBits = {1'b1, 8'h35, 1'b0};
    waitFall(t1);
    repeat (10) @(negedge clk);
    for (int b = 0; b < 10; b++) begin
      chk("R4 bit value", {31'h0, txd}, {31'h0, expBits[b]});
      repeat (20) @(negedge clk);
    end
    wr(5'h08, 32'h0);
    wr(5'h00, 32'hFF); wr(5'h00, 32'hFF);
    wr(5'h08, 32'h1);
    waitFall(t1);
    @(negedge clk); while (txd !== 1'b1) @(negedge clk);
    waitFall(t2);
    chk("R9 one-stop period", t2 - t1, 32'd201);
    repeat (250) @(negedge clk);
    wr(5'h08, 32'h0);
    wr(5'h00, 32'hFF); wr(5'h00, 32'hFF);
    wr(5'h08, 32'h3);
    waitFall(t1);
    @(negedge clk); while (txd !== 1'b1) @(negedge clk);
    waitFall(t2);
    chk("R4 two-stop period", t2 - t1, 32'd221);
    repeat (300) @(negedge clk);
    wr(5'h18, 32'd15);
  endtask

  task automatic testWatermark;
    wr(5'h08, 32'h0004_0000);
    wr(5'h0C, 32'h0);
    rd(5'h14, d); chk("R7 tx below level", d, 32'h1);
    wr(5'h10, 32'h0); chk("R8 masked", {31'h0, irq}, 32'h0);
    wr(5'h10, 32'h1); chk("R8 tx enabled", {31'h0, irq}, 32'h1);
    for (int i = 0; i < 4; i++) wr(5'h00, 32'h41 + i);
    rd(5'h14, d); chk("R7 tx at level", d, 32'h0);
    chk("R8 tx cleared", {31'h0, irq}, 32'h0);
    wr(5'h14, 32'hFFFF_FFFF);
    rd(5'h14, d); chk("R7 write ignored", d, 32'h0);
    loopOn = 1;
    wr(5'h0C, 32'h0001_0001);
    wr(5'h10, 32'h2);
    wr(5'h08, 32'h1);
    repeat (900) @(negedge clk);
    rd(5'h14, d); chk("R7 rx above level", d, 32'h2);
    chk("R8 rx irq", {31'h0, irq}, 32'h1);
    for (int i = 0; i < 3; i++) begin
      rd(5'h04, d); chk("R3 pop", d, 32'h41 + i);
    end
    rd(5'h14, d); chk("R7 not sticky", d, 32'h0);
    chk("R8 rx irq drops", {31'h0, irq}, 32'h0);
    rd(5'h04, d); chk("R3 last", d, 32'h44);
    wr(5'h10, 32'h0);
  endtask

  task automatic testRxDisabled;
    wr(5'h0C, 32'h0);
    wr(5'h00, 32'h66);
    repeat (400) @(negedge clk);
    rd(5'h04, d); chk("R6 disabled receiver", d, 32'h8000_0000);
  endtask

  task automatic sendFrame(input logic [7:0] b, input logic stopBit);
    @(negedge clk);
    benchRx = 0; repeat (16) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      benchRx = b[i]; repeat (16) @(negedge clk);
    end
    benchRx = stopBit; repeat (16) @(negedge clk);
    benchRx = 1; repeat (32) @(negedge clk);
  endtask

  task automatic testBadStop;
    loopOn = 0; benchRx = 1;
    wr(5'h0C, 32'h1);
    sendFrame(8'h5A, 1'b0);
    sendFrame(8'hA5, 1'b1);
    rd(5'h04, d); chk("R10 good frame kept", d, 32'hA5);
    rd(5'h04, d); chk("R10 bad frame dropped", d, 32'h8000_0000);
  endtask

  task automatic testOverflow;
    loopOn = 1;
    wr(5'h0C, 32'h1);
    wr(5'h08, 32'h1);
    for (int i = 0; i < 10; i++) pushWait(8'h80 + 8'(i));
    repeat (2500) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rd(5'h04, d); chk("R11 kept byte", d, 32'h80 + i);
    end
    rd(5'h04, d); chk("R11 extra dropped", d, 32'h8000_0000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testTxFull();
    testTiming();
    testWatermark();
    testRxDisabled();
    testBadStop();
    testOverflow();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule